// File: doc/BRIEF.md
# Keypad Event Byte Queue

This block buffers key press and release events for a keypad controller. Each event arrives on a push port as a 7-bit key code plus a press flag. It is packed into one byte and stored in a 16-slot circular buffer. Every accepted event raises a one-cycle request toward the keypad interrupt logic. A push that finds the buffer full raises a one-cycle overflow pulse toward the error logic. While the error logic reports that an overflow error is already latched and pending, further pushes are dropped silently.

The host has two ways to read. A consuming read moves the head forward first and then returns the slot it now points to. As a result, the oldest slot stays visible to a non-consuming peek at offset 0. A consuming read returns zero, and changes nothing, while one or fewer entries are held. A peek returns the entry at a byte offset from the head. The offset starts at zero on each new read transfer and steps by one with every peek byte. A clear input empties the buffer.

Top module: `key_event_queue`

## Requirements
- R1: After a synchronous reset the buffer is empty, `rd_data_o` is 0x00, and `kev_o` and `ovf_o` are low.
- R2: An accepted push stores a byte with the press flag in bit 7 and the key code in bits 6:0. `kev_o` is high for exactly the cycle after that push.
- R3: A consuming read while the count is 1 or less returns 0x00 and leaves the head and the count unchanged. Otherwise it advances the head by one, lowers the count by one and returns the entry at the new head. The result is on `rd_data_o` the cycle after the strobe.
- R4: A peek byte at offset n returns 0x00 when n is equal to or greater than the count. Otherwise it returns the entry at (head + n) mod 16. A peek leaves the buffer unchanged and raises the offset by one. If a consuming read and a peek are strobed together, the peek is ignored.
- R5: `rd_start_i` marks a new read transfer. A peek in that cycle, and the offset that follows, begin from offset 0.
- R6: Head and write positions wrap modulo 16, so a full buffer whose head is not at slot 0 returns every entry in arrival order.
- R7: A push while 16 entries are held is dropped and leaves the contents intact. `ovf_o` is high for exactly the following cycle and `kev_o` stays low.
- R8: A push while `ovf_held_i` is high is ignored. It stores nothing and raises neither `kev_o` nor `ovf_o`.
- R9: `clr_i` sets the head and the count to zero. A push in the same cycle is dropped without `kev_o`.
- R10: A push and a consuming read in the same cycle both take effect, and the count changes by their net amount.
- R11: `rd_data_o` holds its value until the next consuming read or peek.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Empty the buffer |
| push_i | input | 1 | Push strobe for one event |
| push_code_i | input | 7 | Key code of the pushed event |
| push_down_i | input | 1 | 1 for a press, 0 for a release |
| ovf_held_i | input | 1 | Error logic holds a pending overflow error |
| rd_start_i | input | 1 | Start of a new read transfer |
| rd_pop_i | input | 1 | Consuming read byte strobe |
| rd_peek_i | input | 1 | Non-consuming peek byte strobe |
| rd_data_o | output | 8 | Byte returned by the last read strobe |
| kev_o | output | 1 | Keypad event interrupt request pulse |
| ovf_o | output | 1 | Buffer overflow error pulse |

## Verification
Several properties are checked on every cycle:
- The count never goes above 16.
- An overflow pulse only follows a cycle with a full buffer, and it never coincides with an event pulse.
- Clear always leaves the count at zero.
- A blocked push raises no pulse.
- A short consuming read returns zero.
- A simultaneous push and pop keep the count.

Only the bench scenarios can show that the right byte comes back in the right order. That covers the press flag in bit 7, the oldest slot staying visible after a consuming read, correct wrap on a full buffer whose head is mid-array, the offset restarting on a new transfer, and the contents surviving a dropped push.

// File: rtl/keq_pkg.sv
package keq_pkg;
    localparam int unsigned KEQ_DEPTH  = 16;
    localparam int unsigned KEQ_CODE_W = 7;
    localparam int unsigned KEQ_IDX_W  = $clog2(KEQ_DEPTH);
    localparam int unsigned KEQ_CNT_W  = KEQ_IDX_W + 1;
    localparam int unsigned KEQ_BYTE_W = KEQ_CODE_W + 1;

    typedef struct packed {
        logic                  down;
        logic [KEQ_CODE_W-1:0] code;
    } key_evt_t;

    typedef logic [KEQ_IDX_W-1:0] idx_t;
    typedef logic [KEQ_CNT_W-1:0] cnt_t;

    // slot index reached by stepping n places from a base index
    function automatic idx_t idx_step(idx_t base, cnt_t n);
        return idx_t'(base + idx_t'(n));
    endfunction

    function automatic cnt_t cnt_of_bit(logic b);
        return {{(KEQ_CNT_W-1){1'b0}}, b};
    endfunction
endpackage

// File: rtl/keq_ptrs.sv
module keq_ptrs
    import keq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push_ok,
    input  logic pop_ok,
    output idx_t head,
    output cnt_t cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (pop_ok)
                head <= idx_step(head, cnt_t'(1));
            cnt <= cnt_t'(cnt + cnt_of_bit(push_ok) - cnt_of_bit(pop_ok));
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= cnt_t'(KEQ_DEPTH));

    // R10
    net_count_chk: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/keq_store.sv
module keq_store
    import keq_pkg::*;
(
    input  logic     clk,
    input  logic     we,
    input  idx_t     waddr,
    input  key_evt_t wdata,
    input  idx_t     raddr_a,
    input  idx_t     raddr_b,
    output key_evt_t rdata_a,
    output key_evt_t rdata_b
);
    key_evt_t slot [KEQ_DEPTH];

    for (genvar g = 0; g < KEQ_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == idx_t'(g)))
                slot[g] <= wdata;
        end
    end

    assign rdata_a = slot[raddr_a];
    assign rdata_b = slot[raddr_b];
endmodule

// File: rtl/keq_rdport.sv
module keq_rdport
    import keq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  pop,
    input  logic                  peek,
    input  idx_t                  head,
    input  cnt_t                  cnt,
    input  key_evt_t              pop_slot,
    input  key_evt_t              peek_slot,
    output idx_t                  pop_addr,
    output idx_t                  peek_addr,
    output logic [KEQ_BYTE_W-1:0] data
);
    cnt_t off_q;
    cnt_t eff_off;
    cnt_t next_off;

    always_comb begin
        eff_off   = start ? '0 : off_q;
        pop_addr  = idx_step(head, cnt_t'(1));
        peek_addr = idx_step(head, eff_off);
        next_off  = eff_off;
        if (peek && !pop && (eff_off != cnt_t'(KEQ_DEPTH)))
            next_off = cnt_t'(eff_off + cnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            data  <= '0;
        end else begin
            off_q <= next_off;
            if (pop)
                data <= (cnt > cnt_t'(1)) ? pop_slot : '0;
            else if (peek)
                data <= (eff_off < cnt) ? peek_slot : '0;
        end
    end

    // R5
    start_off_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !peek) |=> (off_q == '0));
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import keq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  push_i,
    input  logic [KEQ_CODE_W-1:0] push_code_i,
    input  logic                  push_down_i,
    input  logic                  ovf_held_i,
    input  logic                  rd_start_i,
    input  logic                  rd_pop_i,
    input  logic                  rd_peek_i,
    output logic [KEQ_BYTE_W-1:0] rd_data_o,
    output logic                  kev_o,
    output logic                  ovf_o
);
    idx_t     head;
    cnt_t     cnt;
    idx_t     pop_addr;
    idx_t     peek_addr;
    key_evt_t pop_slot;
    key_evt_t peek_slot;
    key_evt_t new_evt;
    logic     full;
    logic     push_try;
    logic     push_ok;
    logic     push_drop;
    logic     pop_ok;

    always_comb begin
        full          = (cnt == cnt_t'(KEQ_DEPTH));
        push_try      = push_i && !clr_i && !ovf_held_i;
        push_ok       = push_try && !full;
        push_drop     = push_try && full;
        pop_ok        = rd_pop_i && !clr_i && (cnt > cnt_t'(1));
        new_evt.down  = push_down_i;
        new_evt.code  = push_code_i;
    end

    keq_ptrs u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_i),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .head    (head),
        .cnt     (cnt)
    );

    keq_store u_store (
        .clk     (clk),
        .we      (push_ok),
        .waddr   (idx_step(head, cnt)),
        .wdata   (new_evt),
        .raddr_a (pop_addr),
        .raddr_b (peek_addr),
        .rdata_a (pop_slot),
        .rdata_b (peek_slot)
    );

    keq_rdport u_rd (
        .clk       (clk),
        .rst       (rst),
        .start     (rd_start_i),
        .pop       (rd_pop_i),
        .peek      (rd_peek_i),
        .head      (head),
        .cnt       (cnt),
        .pop_slot  (pop_slot),
        .peek_slot (peek_slot),
        .pop_addr  (pop_addr),
        .peek_addr (peek_addr),
        .data      (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kev_o <= 1'b0;
            ovf_o <= 1'b0;
        end else begin
            kev_o <= push_ok;
            ovf_o <= push_drop;
        end
    end

    // R3
    short_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_pop_i && !clr_i && (cnt <= cnt_t'(1))) |=> (rd_data_o == '0));

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt == '0));

    // R8
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && ovf_held_i) |=> (!kev_o && !ovf_o));

    // R7
    ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(cnt) == cnt_t'(KEQ_DEPTH)));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(kev_o && ovf_o));
endmodule

// File: tb/tb_key_event_queue.sv
`timescale 1ns/1ps
module tb_key_event_queue;
    logic       clk = 1'b0;
    logic       rst;
    logic       clr_i, push_i, push_down_i, ovf_held_i;
    logic [6:0] push_code_i;
    logic       rd_start_i, rd_pop_i, rd_peek_i;
    logic [7:0] rd_data_o;
    logic       kev_o, ovf_o;

    always #2.5 clk = ~clk;

    key_event_queue dut (
        .clk(clk), .rst(rst), .clr_i(clr_i), .push_i(push_i),
        .push_code_i(push_code_i), .push_down_i(push_down_i),
        .ovf_held_i(ovf_held_i), .rd_start_i(rd_start_i),
        .rd_pop_i(rd_pop_i), .rd_peek_i(rd_peek_i),
        .rd_data_o(rd_data_o), .kev_o(kev_o), .ovf_o(ovf_o)
    );

    typedef struct {
        logic [7:0] data;
        logic       kev;
        logic       ovf;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [7:0] m_mem [16];
    int m_head = 0, m_cnt = 0, m_off = 0;
    logic [7:0] m_data = 8'h00;

    // monitor: compares one expected item per cycle, just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (rd_data_o !== e.data || kev_o !== e.kev || ovf_o !== e.ovf) begin
                failures++;
                $display("FAIL %s: data=%02h kev=%0b ovf=%0b expected data=%02h kev=%0b ovf=%0b",
                         e.req, rd_data_o, kev_o, ovf_o, e.data, e.kev, e.ovf);
            end
        end
    end

    task automatic step(input bit push, input logic [6:0] code, input bit down,
                        input bit pop, input bit peek, input bit start,
                        input bit clr, input bit held, input string req);
        exp_t e;
        int eoff;
        bit acc, drop;
        @(negedge clk);
        push_i = push; push_code_i = code; push_down_i = down;
        rd_pop_i = pop; rd_peek_i = peek; rd_start_i = start;
        clr_i = clr; ovf_held_i = held;
        eoff = start ? 0 : m_off;
        acc  = push && !clr && !held && (m_cnt < 16);
        drop = push && !clr && !held && (m_cnt == 16);
        if (pop) begin
            m_data = (m_cnt > 1) ? m_mem[(m_head + 1) % 16] : 8'h00;
        end else if (peek) begin
            m_data = (eoff < m_cnt) ? m_mem[(m_head + eoff) % 16] : 8'h00;
            eoff = (eoff < 16) ? eoff + 1 : 16;
        end
        m_off = eoff;
        e.data = m_data; e.kev = acc; e.ovf = drop; e.req = req;
        exp_q.push_back(e);
        if (clr) begin
            m_head = 0; m_cnt = 0;
        end else begin
            if (acc) m_mem[(m_head + m_cnt) % 16] = {down, code};
            if (pop && m_cnt > 1) begin
                m_head = (m_head + 1) % 16;
                m_cnt  = m_cnt - 1;
            end
            if (acc) m_cnt = m_cnt + 1;
        end
    endtask

    task automatic push_ev(input logic [6:0] code, input bit down, input string req);
        step(1, code, down, 0, 0, 0, 0, 0, req);
    endtask
    task automatic pop_rd(input string req);
        step(0, 0, 0, 1, 0, 0, 0, 0, req);
    endtask
    task automatic peek_rd(input bit start, input string req);
        step(0, 0, 0, 0, 1, start, 0, 0, req);
    endtask
    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; clr_i = 0; push_i = 0; push_code_i = 0; push_down_i = 0;
        ovf_held_i = 0; rd_start_i = 0; rd_pop_i = 0; rd_peek_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        checks++;
        if (rd_data_o !== 8'h00 || kev_o !== 1'b0 || ovf_o !== 1'b0) begin
            failures++;
            $display("FAIL R1: data=%02h kev=%0b ovf=%0b expected 00 0 0", rd_data_o, kev_o, ovf_o);
        end
        peek_rd(1, "R1");                       // empty: peek returns zero

        // R2 packing and event pulse
        push_ev(7'h3c, 1, "R2");
        push_ev(7'h11, 0, "R2");
        push_ev(7'h7f, 1, "R2");
        // R4 peeks at offsets 0..3
        peek_rd(1, "R4");
        peek_rd(0, "R4");
        peek_rd(0, "R4");
        peek_rd(0, "R4");                       // offset 3 >= count 3 -> zero
        peek_rd(1, "R5");                       // new transfer restarts at 0
        idle("R11");
        idle("R11");
        // R3 consuming reads
        pop_rd("R3");
        pop_rd("R3");
        pop_rd("R3");                           // one left -> zero
        peek_rd(1, "R3");                       // oldest slot still visible
        peek_rd(0, "R3");
        // R9 clear and clear with push
        step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
        peek_rd(1, "R9");
        step(1, 7'h22, 1, 0, 0, 0, 1, 0, "R9");
        peek_rd(1, "R9");
        // R6 move head mid-array, then fill
        for (int i = 0; i < 5; i++) push_ev(7'(i + 1), i[0], "R6");
        for (int i = 0; i < 4; i++) pop_rd("R6");
        for (int i = 0; i < 15; i++) push_ev(7'(8'h40 + i), ~i[0], "R6");
        // R7 full push dropped
        push_ev(7'h55, 1, "R7");
        idle("R7");
        for (int i = 0; i < 16; i++) peek_rd(i == 0, "R6");
        // R8 blocked push after making room
        pop_rd("R8");
        step(1, 7'h66, 1, 0, 0, 0, 0, 1, "R8");
        idle("R8");
        peek_rd(1, "R8");
        for (int i = 1; i < 16; i++) peek_rd(0, "R8");
        // R10 push and pop together
        step(1, 7'h0a, 0, 1, 0, 0, 0, 0, "R10");
        step(1, 7'h0b, 1, 1, 0, 0, 0, 0, "R10");
        for (int i = 0; i < 16; i++) peek_rd(i == 0, "R10");
        push_ev(7'h0c, 0, "R10");              // count was 15 -> accepted
        push_ev(7'h0d, 0, "R7");               // now full -> dropped
        idle("R11");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule